// File: doc/BRIEF.md
# DRAM Refresh Counter Test Sequencer

This block is a self-checking test engine for the refresh address counter built into a DRAM. It sits above a simple command port and drives four kinds of command: a refresh cycle with the column strobe asserted before the row strobe, a normal write, a normal read, and a counter-test read-modify-write cycle. In the counter-test cycle the DRAM takes the row from its own refresh counter and the column from the command. The block never names a row during the counter phases. It relies on exactly one counter-driven cycle per row, so any skip or repeat in the DRAM counter leaves a row holding the wrong value.

After a start pulse the sequencer issues the wake-up refresh cycles and fills the array with a background value. It then makes two counter passes at a chosen column. Each pass flips the cells there and is followed by a normal read-back of every row. The whole procedure runs once with background 0 and once with background 1. Every read is compared with its expected value. The first mismatch is recorded and the run continues to the end. When the run finishes, `done` rises; a clear `fail` at that point means the array and counter passed.

Top module: `rfshCtrTest`

## Requirements
- R1: After a start pulse, the first INIT_CYCLES (default 8) commands are refresh cycles, op code 0. No other command comes before them.
- R2: The fill phase writes the background value to every cell with normal writes, op code 1. The column is the inner loop, starting at row 0, column 0. The first pass uses background 0.
- R3: The first counter phase issues one read-modify-write (op code 3) per row, 2**ROW_W in total, all at the latched test column. Each writes the complement of the background and expects to read the background.
- R4: The first read-back phase issues a normal read (op code 2) at the test column of every row, rows ascending, and expects the complement of the background.
- R5: The second counter phase issues 2**ROW_W more read-modify-write cycles at the same column that write the background and expect its complement. A second read-back then expects the background.
- R6: After the background-0 pass the whole sequence repeats with background 1. Then `done` rises, `busy` falls and no command is outstanding. The full run is INIT_CYCLES + 2*(2**(ROW_W+COL_W) + 4*2**ROW_W) commands.
- R7: A read result that differs from its expected value sets `fail`. It records the row and column: in counter phases the row is the counter cycle index from 0. Later mismatches change neither `fail` nor the recorded position, and the sequence still runs to `done`.
- R8: While `cmdValid` is high and `cmdAck` is low, the command fields stay stable and `cmdValid` stays high. A command completes on the cycle `cmdAck` is high, and `rspData` is sampled then.
- R9: A start pulse while busy has no effect: neither the command stream nor the test column changes.
- R10: A start pulse after `done` begins a new run with `fail` cleared and the test column re-latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle or done |
| testColIn | input | COL_W | Column used by the counter and read-back phases, latched at start |
| cmdValid | output | 1 | Command request |
| cmdOp | output | 2 | 0 refresh, 1 write, 2 read, 3 counter read-modify-write |
| cmdRow | output | ROW_W | Row for write and read (zero otherwise) |
| cmdCol | output | COL_W | Column for write, read and read-modify-write |
| cmdData | output | 1 | Write data for write and read-modify-write |
| cmdAck | input | 1 | Command accepted; read data valid |
| rspData | input | 1 | Data read by a read or read-modify-write |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete |
| fail | output | 1 | At least one mismatch in this run |
| failRow | output | ROW_W | Row (or counter cycle index) of the first mismatch |
| failCol | output | COL_W | Column of the first mismatch |

## Verification
A wrong phase or index register shows up at once in the command stream. A skipped refresh, a shifted fill order or a wrong column is visible on the very command that follows it, so the bench compares every accepted command against its expected order.

A wrong background or complement shows up in two ways. It corrupts the write data at once, and it corrupts the expected read value on the next compare, which gives a spurious `fail`.

Faults in the modelled DRAM must reach `failRow` and `failCol` at the first mismatching cycle:
- a stuck cell is caught during the first counter pass;
- a counter that fails to advance is caught on the repeated row.

// File: rtl/rfshCtrTestPkg.sv
package rfshCtrTestPkg;

  typedef enum logic [1:0] {
    OP_REFRESH = 2'd0,
    OP_WRITE   = 2'd1,
    OP_READ    = 2'd2,
    OP_CTR_RMW = 2'd3
  } cmdOp_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_INIT  = 3'd1,
    PH_FILL  = 3'd2,
    PH_CNT_A = 3'd3,
    PH_RD_A  = 3'd4,
    PH_CNT_B = 3'd5,
    PH_RD_B  = 3'd6,
    PH_DONE  = 3'd7
  } phase_e;

  typedef struct packed {
    logic   loadStart;
    logic   clearIdx;
    logic   advance;
    logic   compare;
    logic   flipBg;
    phase_e phase;
  } seqCtl_t;

endpackage

// File: rtl/rfshCtrTestCtrl.sv
module rfshCtrTestCtrl
  import rfshCtrTestPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    cmdAck,
  input  logic    lastItem,
  output seqCtl_t ctl,
  output logic    cmdValid,
  output logic    busy,
  output logic    done
);

  phase_e state, stateNxt;
  logic   passTwo, passTwoNxt;

  function automatic phase_e nextPhase(input phase_e ph);
    case (ph)
      PH_INIT:  return PH_FILL;
      PH_FILL:  return PH_CNT_A;
      PH_CNT_A: return PH_RD_A;
      PH_RD_A:  return PH_CNT_B;
      PH_CNT_B: return PH_RD_B;
      default:  return PH_DONE;
    endcase
  endfunction

  always_comb begin
    ctl        = '0;
    ctl.phase  = state;
    stateNxt   = state;
    passTwoNxt = passTwo;
    case (state)
      PH_IDLE, PH_DONE: begin
        if (start) begin
          ctl.loadStart = 1'b1;
          stateNxt      = PH_INIT;
          passTwoNxt    = 1'b0;
        end
      end
      default: begin
        if (cmdAck) begin
          ctl.compare = (state != PH_INIT) && (state != PH_FILL);
          if (lastItem) begin
            ctl.clearIdx = 1'b1;
            if (state == PH_RD_B) begin
              if (passTwo) begin
                stateNxt = PH_DONE;
              end else begin
                ctl.flipBg = 1'b1;
                passTwoNxt = 1'b1;
                stateNxt   = PH_FILL;
              end
            end else begin
              stateNxt = nextPhase(state);
            end
          end else begin
            ctl.advance = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PH_IDLE;
      passTwo <= 1'b0;
    end else begin
      state   <= stateNxt;
      passTwo <= passTwoNxt;
    end
  end

  assign cmdValid = (state != PH_IDLE) && (state != PH_DONE);
  assign busy     = cmdValid;
  assign done     = (state == PH_DONE);

endmodule

// File: rtl/rfshCtrTestPath.sv
module rfshCtrTestPath
  import rfshCtrTestPkg::*;
#(
  parameter int ROW_W       = 10,
  parameter int COL_W       = 11,
  parameter int INIT_CYCLES = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [COL_W-1:0] testColIn,
  input  logic             rspData,
  output logic             lastItem,
  output logic [1:0]       cmdOp,
  output logic [ROW_W-1:0] cmdRow,
  output logic [COL_W-1:0] cmdCol,
  output logic             cmdData,
  output logic             fail,
  output logic [ROW_W-1:0] failRow,
  output logic [COL_W-1:0] failCol
);

  localparam int INIT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES - 1);

  logic [ROW_W-1:0]  rowIdx;
  logic [COL_W-1:0]  colIdx;
  logic [INIT_W-1:0] initIdx;
  logic [COL_W-1:0]  testCol;
  logic              bg;
  logic              rowLast, colLast, initLast;
  logic              expectBit;
  cmdOp_e            opSel;

  assign rowLast  = &rowIdx;
  assign colLast  = &colIdx;
  assign initLast = (initIdx == INIT_LAST);

  always_comb begin
    case (ctl.phase)
      PH_INIT: lastItem = initLast;
      PH_FILL: lastItem = rowLast && colLast;
      default: lastItem = rowLast;
    endcase
  end

  always_comb begin
    opSel     = OP_REFRESH;
    cmdRow    = '0;
    cmdCol    = '0;
    cmdData   = 1'b0;
    expectBit = bg;
    case (ctl.phase)
      PH_FILL: begin
        opSel   = OP_WRITE;
        cmdRow  = rowIdx;
        cmdCol  = colIdx;
        cmdData = bg;
      end
      PH_CNT_A: begin
        opSel     = OP_CTR_RMW;
        cmdCol    = testCol;
        cmdData   = ~bg;
        expectBit = bg;
      end
      PH_RD_A: begin
        opSel     = OP_READ;
        cmdRow    = rowIdx;
        cmdCol    = testCol;
        expectBit = ~bg;
      end
      PH_CNT_B: begin
        opSel     = OP_CTR_RMW;
        cmdCol    = testCol;
        cmdData   = bg;
        expectBit = ~bg;
      end
      PH_RD_B: begin
        opSel     = OP_READ;
        cmdRow    = rowIdx;
        cmdCol    = testCol;
        expectBit = bg;
      end
      default: ;
    endcase
  end

  assign cmdOp = opSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowIdx  <= '0;
      colIdx  <= '0;
      initIdx <= '0;
    end else if (ctl.loadStart || ctl.clearIdx) begin
      rowIdx  <= '0;
      colIdx  <= '0;
      initIdx <= '0;
    end else if (ctl.advance) begin
      case (ctl.phase)
        PH_INIT: initIdx <= initIdx + 1'b1;
        PH_FILL: begin
          colIdx <= colIdx + 1'b1;
          if (colLast) rowIdx <= rowIdx + 1'b1;
        end
        default: rowIdx <= rowIdx + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testCol <= '0;
      bg      <= 1'b0;
    end else if (ctl.loadStart) begin
      testCol <= testColIn;
      bg      <= 1'b0;
    end else if (ctl.flipBg) begin
      bg <= ~bg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fail    <= 1'b0;
      failRow <= '0;
      failCol <= '0;
    end else if (ctl.loadStart) begin
      fail    <= 1'b0;
      failRow <= '0;
      failCol <= '0;
    end else if (ctl.compare && (rspData != expectBit) && !fail) begin
      fail    <= 1'b1;
      failRow <= rowIdx;
      failCol <= testCol;
    end
  end

endmodule

// File: rtl/rfshCtrTest.sv
module rfshCtrTest
  import rfshCtrTestPkg::*;
#(
  parameter int ROW_W       = 10,
  parameter int COL_W       = 11,
  parameter int INIT_CYCLES = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [COL_W-1:0] testColIn,
  output logic             cmdValid,
  output logic [1:0]       cmdOp,
  output logic [ROW_W-1:0] cmdRow,
  output logic [COL_W-1:0] cmdCol,
  output logic             cmdData,
  input  logic             cmdAck,
  input  logic             rspData,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [ROW_W-1:0] failRow,
  output logic [COL_W-1:0] failCol
);

  seqCtl_t ctl;
  logic    lastItem;

  rfshCtrTestCtrl ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cmdAck   (cmdAck),
    .lastItem (lastItem),
    .ctl      (ctl),
    .cmdValid (cmdValid),
    .busy     (busy),
    .done     (done)
  );

  rfshCtrTestPath #(
    .ROW_W       (ROW_W),
    .COL_W       (COL_W),
    .INIT_CYCLES (INIT_CYCLES)
  ) path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .testColIn (testColIn),
    .rspData   (rspData),
    .lastItem  (lastItem),
    .cmdOp     (cmdOp),
    .cmdRow    (cmdRow),
    .cmdCol    (cmdCol),
    .cmdData   (cmdData),
    .fail      (fail),
    .failRow   (failRow),
    .failCol   (failCol)
  );

endmodule

// File: rtl/rfshCtrTestChk.sv
module rfshCtrTestChk #(
  parameter int ROW_W = 10,
  parameter int COL_W = 11
)(
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             cmdValid,
  input logic [1:0]       cmdOp,
  input logic [ROW_W-1:0] cmdRow,
  input logic [COL_W-1:0] cmdCol,
  input logic             cmdData,
  input logic             cmdAck,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic [ROW_W-1:0] failRow,
  input logic [COL_W-1:0] failCol
);

  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdAck) |=> cmdValid);

  assert_hold_fields_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdAck) |=> ($stable(cmdOp) && $stable(cmdRow)
                               && $stable(cmdCol) && $stable(cmdData)));

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!cmdValid && !busy));

  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !start) |=> fail);

  assert_fail_pos_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !start) |=> ($stable(failRow) && $stable(failCol)));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !cmdAck) |=> busy);

  assert_restart_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> (busy && !fail));

endmodule

bind rfshCtrTest rfshCtrTestChk #(.ROW_W(ROW_W), .COL_W(COL_W)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdRow   (cmdRow),
  .cmdCol   (cmdCol),
  .cmdData  (cmdData),
  .cmdAck   (cmdAck),
  .busy     (busy),
  .done     (done),
  .fail     (fail),
  .failRow  (failRow),
  .failCol  (failCol)
);

// File: tb/rfshCtrTest_test.sv
`timescale 1ns/1ps
module rfshCtrTest_test;

  localparam int ROW_W = 2;
  localparam int COL_W = 2;
  localparam int INITC = 8;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] testColIn = '0;
  logic             cmdValid, cmdData, cmdAck, rspData;
  logic [1:0]       cmdOp;
  logic [ROW_W-1:0] cmdRow, failRow;
  logic [COL_W-1:0] cmdCol, failCol;
  logic             busy, done, fail;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  rfshCtrTest #(.ROW_W(ROW_W), .COL_W(COL_W), .INIT_CYCLES(INITC)) uut (
    .clk(clk), .rstN(rstN), .start(start), .testColIn(testColIn),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdRow(cmdRow), .cmdCol(cmdCol),
    .cmdData(cmdData), .cmdAck(cmdAck), .rspData(rspData),
    .busy(busy), .done(done), .fail(fail), .failRow(failRow), .failCol(failCol)
  );

  // DRAM model with fault injection
  logic [ROWS*COLS-1:0] mem;
  logic [ROW_W-1:0]     ctr;
  int                   faultMode = 0;
  int                   faultRow = 0, faultCol = 0;
  int                   rmwCount = 0;

  function automatic logic cellVal(input int r, input int c);
    if (faultMode == 1 && r == faultRow && c == faultCol) return 1'b1;
    return mem[r*COLS + c];
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdAck  <= 1'b0;
      rspData <= 1'b0;
      ctr     <= '0;
      mem     <= '0;
    end else if (cmdValid && !cmdAck) begin
      cmdAck <= 1'b1;
      case (cmdOp)
        2'd0: ctr <= ctr + 1'b1;
        2'd1: mem[int'(cmdRow)*COLS + int'(cmdCol)] <= cmdData;
        2'd2: rspData <= cellVal(int'(cmdRow), int'(cmdCol));
        default: begin
          rspData <= cellVal(int'(ctr), int'(cmdCol));
          mem[int'(ctr)*COLS + int'(cmdCol)] <= cmdData;
          if (!(faultMode == 2 && rmwCount == 1)) ctr <= ctr + 1'b1;
          rmwCount <= rmwCount + 1;
        end
      endcase
    end else begin
      cmdAck <= 1'b0;
    end
  end

  // scoreboard
  typedef struct {
    logic [1:0] op;
    int         row;
    int         col;
    logic       data;
    string      tag;
  } item_t;

  item_t expQ[$];

  task automatic push(input logic [1:0] op, input int r, input int c,
                      input logic d, input string tag);
    item_t it;
    it.op = op; it.row = r; it.col = c; it.data = d; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic pushStream(input int tcol);
    for (int i = 0; i < INITC; i++) push(2'd0, 0, 0, 1'b0, "R1");
    for (int p = 0; p < 2; p++) begin
      logic bgv;
      bgv = (p == 1);
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          push(2'd1, r, c, bgv, (p == 0) ? "R2" : "R6");
      for (int r = 0; r < ROWS; r++) push(2'd3, 0, tcol, ~bgv, (p == 0) ? "R3" : "R6");
      for (int r = 0; r < ROWS; r++) push(2'd2, r, tcol, 1'b0, (p == 0) ? "R4" : "R6");
      for (int r = 0; r < ROWS; r++) push(2'd3, 0, tcol, bgv, (p == 0) ? "R5" : "R6");
      for (int r = 0; r < ROWS; r++) push(2'd2, r, tcol, 1'b0, (p == 0) ? "R5" : "R6");
    end
  endtask

  always @(negedge clk) begin
    if (rstN && cmdValid && cmdAck) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R6: unexpected command op=%0d (expected none)", cmdOp);
      end else begin
        item_t e;
        logic bad;
        e = expQ.pop_front();
        bad = (cmdOp != e.op);
        if (e.op == 2'd1 || e.op == 2'd2) bad |= (int'(cmdRow) != e.row);
        if (e.op != 2'd0) bad |= (int'(cmdCol) != e.col);
        if (e.op == 2'd1 || e.op == 2'd3) bad |= (cmdData != e.data);
        if (bad) begin
          errors++;
          $display("FAIL %s: cmd op=%0d row=%0d col=%0d data=%0d expected op=%0d row=%0d col=%0d data=%0d",
                   e.tag, cmdOp, cmdRow, cmdCol, cmdData, e.op, e.row, e.col, e.data);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one full run
  task automatic runTest(input int tcol, input int mode, input bit expFail,
                         input int expRow, input bit poke);
    int cyc;
    faultMode = mode;
    rmwCount  = 0;
    pushStream(tcol);
    @(negedge clk);
    testColIn = tcol[COL_W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !fail, "R10", {30'd0, busy, fail}, 2);
    cyc = 0;
    while (!done && cyc < 5000) begin
      if (poke && cyc == 20) begin
        start = 1'b1;
        testColIn = ~tcol[COL_W-1:0];
      end else if (poke && cyc == 21) begin
        start = 1'b0;
        testColIn = tcol[COL_W-1:0];
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done && !busy && !cmdValid, "R6", {29'd0, done, busy, cmdValid}, 4);
    check(expQ.size() == 0, "R6", expQ.size(), 0);
    check(fail == expFail, "R7", fail, expFail);
    if (expFail) begin
      check(int'(failRow) == expRow, "R7", failRow, expRow);
      check(int'(failCol) == tcol, "R7", failCol, tcol);
    end
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !cmdValid, "R6",
          {28'd0, busy, done, fail, cmdValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // clean run, column 1
    runTest(1, 0, 1'b0, 0, 1'b0);
    // clean run, column 2, start pulsed mid-run with other column (R9)
    runTest(2, 0, 1'b0, 0, 1'b1);
    // stuck-at-1 cell at row 2 of the test column (R7): caught at counter index 2
    faultRow = 2; faultCol = 1;
    runTest(1, 1, 1'b1, 2, 1'b0);
    // stuck cell off the test column is never read
    faultRow = 1; faultCol = 0;
    runTest(3, 1, 1'b0, 0, 1'b0);
    // restart after failing run clears fail (R10)
    runTest(0, 0, 1'b0, 0, 1'b0);
    // counter fails to advance once: row 1 hit twice, mismatch at index 2 (R3)
    runTest(3, 2, 1'b1, 2, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL R6: watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule